// File: doc/BRIEF.md
# Policy-Based Buffer Pointer Allocator

This block hands out and takes back buffer pointers for a set of allocation policies. A client issues one request per cycle. The request names a policy and is either a pop, which asks for a buffer, or a push, which returns one. A pop is answered one cycle later with a 64-bit reply word. The reply carries the pool the buffer came from and the 36-bit pointer. If no pool can grant, the reply is a null word. A push carries the same layout and returns its pointer to the free list of the pool named in the word.

Each policy owns up to four ordered pool slots. Each slot has its own cap on buffers held from that pool. Each policy also has a total cap, a guaranteed count and a group. Grants beyond the guarantee draw on a shared per-group availability count, and pushes above the guarantee refill it. Each pool's free list is an internal pointer FIFO that fills through pushes.

Configuration arrives as static, flattened input vectors. The block keeps counters per policy (allocated, null replies), per policy and pool (allocated), and per pool (pops, pushes, fill level). Per-group availability is loaded from its configuration port during reset.

Top module: `bufptr_alloc`

## Requirements
- R1: A pop request yields `rsp_valid` high for exactly one cycle, at the first clock edge after the request. A successful reply has the pool index in bits 63:56, zeros in bits 55:36 and the pointer in bits 35:0. No reply is produced without a pop request.
- R2: A pop that no pool can grant returns the null word: 0xFF in bits 63:56, zeros in bits 55:36 and all ones in bits 35:0. It also increments the policy's null counter.
- R3: Slot s of policy p is the byte `cfg_pool_map[(p*SLOTS+s)*8 +: 8]`. Slots are tried from 0 upward and the first eligible pool wins. A slot holding a pool ID of `N_POOL` or more is skipped.
- R4: A pool that is empty, or whose `pool_pop_en` bit is clear, is skipped.
- R5: A slot is skipped when the policy's allocated count for that slot's pool has reached the slot's cap.
- R6: A pop gets the null reply when the policy's total allocated count has reached its maximum.
- R7: A grant is covered by the guarantee when the policy's count is below its guaranteed count and the pool's `pool_guar_en` bit is set. Any other grant needs a nonzero availability count in the policy's group and decrements it.
- R8: An accepted push writes the pointer into the named pool's FIFO and raises that pool's level and push counter by one. Pointers leave a pool in the order they entered.
- R9: An accepted push decrements the policy's total and per-pool counts, saturating at zero. It increments the group's availability when the policy's count before the push exceeds its guaranteed count, or when the pool's `pool_guar_en` bit is clear.
- R10: While `pop_dis` is high, every pop gets the null reply and no pool changes. While `push_dis` is high, a push changes no state.
- R11: A push naming a pool ID of `N_POOL` or more, or a full pool, changes no state.
- R12: After reset all counters and pool levels are zero, `rsp_valid` is low, and each group's availability equals its `cfg_grp_avail` field.
- R13: A grant raises the granting pool's pop counter by one and lowers its level by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_push | input | 1 | 1 = push, 0 = pop |
| req_policy | input | $clog2(N_POL) | Policy index |
| req_word | input | 64 | Push word: pool ID 63:56, pointer 35:0 |
| pop_dis | input | 1 | Block all pops (null reply) |
| push_dis | input | 1 | Ignore all pushes |
| pool_pop_en | input | N_POOL | Per-pool pop enable |
| pool_guar_en | input | N_POOL | Per-pool permission to use the guarantee |
| cfg_pool_map | input | N_POL*SLOTS*8 | Pool ID per policy slot |
| cfg_slot_max | input | N_POL*SLOTS*CNT_W | Cap per policy slot |
| cfg_pol_max | input | N_POL*CNT_W | Policy total cap |
| cfg_pol_min | input | N_POL*CNT_W | Policy guaranteed count |
| cfg_pol_grp | input | N_POL*GRP_W | Policy group index |
| cfg_grp_avail | input | N_GRP*CNT_W | Group availability loaded at reset |
| rsp_valid | output | 1 | Pop reply valid |
| rsp_word | output | 64 | Pop reply word |
| pol_alloc_cnt | output | N_POL*CNT_W | Allocated count per policy |
| pol_null_cnt | output | N_POL*CNT_W | Null replies per policy |
| pool_pop_cnt | output | N_POOL*CNT_W | Grants per pool |
| pool_push_cnt | output | N_POOL*CNT_W | Accepted pushes per pool |
| pool_level | output | N_POOL*($clog2(DEPTH)+1) | Pointers held per pool |
| grp_avail | output | N_GRP*CNT_W | Availability per group |

## Verification
The reply word and every counter, level and availability value settle at the first rising edge after the request cycle. The bench drives each request at a falling edge and removes it at the next falling edge. The reply and counters are therefore compared at that second falling edge, half a period after they change. Expected replies are queued by the driver in request order. The monitor takes the head of the queue whenever `rsp_valid` is seen, so an early, late, missing or extra reply shows up as a mismatch.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  localparam int PTR_W  = 36;
  localparam int WORD_W = 64;
  localparam int PID_W  = 8;
  localparam logic [PID_W-1:0]  NULL_PID = 8'hFF;
  localparam logic [WORD_W-1:0] NULL_WORD = {NULL_PID, 20'h0, {PTR_W{1'b1}}};

  function automatic logic [WORD_W-1:0] mk_word(input logic [PID_W-1:0] pid,
                                                input logic [PTR_W-1:0] ptr);
    return {pid, 20'h0, ptr};
  endfunction
endpackage

// File: rtl/bpa_pool_fifo.sv
module bpa_pool_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 36,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign full  = (level == (AW+1)'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/bpa_pick.sv
module bpa_pick #(
  parameter int SLOTS  = 4,
  parameter int N_POOL = 4,
  parameter int CNT_W  = 8,
  parameter int IW     = $clog2(N_POOL)
) (
  input  logic [SLOTS*8-1:0]      slot_pid,
  input  logic [SLOTS*CNT_W-1:0]  slot_cap,
  input  logic [N_POOL*CNT_W-1:0] pp_cnt,
  input  logic [CNT_W-1:0]        pol_cnt,
  input  logic [CNT_W-1:0]        pol_max,
  input  logic [CNT_W-1:0]        pol_min,
  input  logic [CNT_W-1:0]        grp_free,
  input  logic [N_POOL-1:0]       pop_en,
  input  logic [N_POOL-1:0]       guar_en,
  input  logic [N_POOL-1:0]       nonempty,
  output logic                    hit,
  output logic [IW-1:0]           idx,
  output logic                    draw
);
  localparam logic [7:0] POOL_LIM = 8'(N_POOL);

  logic [7:0]    pid;
  logic [IW-1:0] pi;
  logic          guar;
  logic          eligible;

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    draw     = 1'b0;
    pid      = '0;
    pi       = '0;
    guar     = 1'b0;
    eligible = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      pid  = slot_pid[s*8 +: 8];
      pi   = pid[IW-1:0];
      guar = (pol_cnt < pol_min) && guar_en[pi];
      eligible = (pid < POOL_LIM) && pop_en[pi] && nonempty[pi]
              && (pp_cnt[int'(pi)*CNT_W +: CNT_W] < slot_cap[s*CNT_W +: CNT_W])
              && (pol_cnt < pol_max)
              && (guar || (grp_free != '0));
      if (!hit && eligible) begin
        hit  = 1'b1;
        idx  = pi;
        draw = !guar;
      end
    end
  end
endmodule

// File: rtl/bufptr_alloc.sv
module bufptr_alloc #(
  parameter int N_POL  = 4,
  parameter int N_POOL = 4,
  parameter int N_GRP  = 2,
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 16,
  parameter int PW     = $clog2(N_POL),
  parameter int GRP_W  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  parameter int LW     = $clog2(DEPTH) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_push,
  input  logic [PW-1:0]             req_policy,
  input  logic [63:0]               req_word,
  input  logic                      pop_dis,
  input  logic                      push_dis,
  input  logic [N_POOL-1:0]         pool_pop_en,
  input  logic [N_POOL-1:0]         pool_guar_en,
  input  logic [N_POL*SLOTS*8-1:0]  cfg_pool_map,
  input  logic [N_POL*SLOTS*CNT_W-1:0] cfg_slot_max,
  input  logic [N_POL*CNT_W-1:0]    cfg_pol_max,
  input  logic [N_POL*CNT_W-1:0]    cfg_pol_min,
  input  logic [N_POL*GRP_W-1:0]    cfg_pol_grp,
  input  logic [N_GRP*CNT_W-1:0]    cfg_grp_avail,
  output logic                      rsp_valid,
  output logic [63:0]               rsp_word,
  output logic [N_POL*CNT_W-1:0]    pol_alloc_cnt,
  output logic [N_POL*CNT_W-1:0]    pol_null_cnt,
  output logic [N_POOL*CNT_W-1:0]   pool_pop_cnt,
  output logic [N_POOL*CNT_W-1:0]   pool_push_cnt,
  output logic [N_POOL*LW-1:0]      pool_level,
  output logic [N_GRP*CNT_W-1:0]    grp_avail
);
  import bpa_pkg::*;

  localparam int IW = $clog2(N_POOL);
  localparam logic [7:0] POOL_LIM = 8'(N_POOL);

  // ---------------- state ----------------
  logic [CNT_W-1:0] pol_cnt  [N_POL];
  logic [CNT_W-1:0] null_cnt [N_POL];
  logic [CNT_W-1:0] pp_cnt   [N_POL][N_POOL];
  logic [CNT_W-1:0] pop_cnt  [N_POOL];
  logic [CNT_W-1:0] push_cnt [N_POOL];
  logic [CNT_W-1:0] grp_free [N_GRP];

  // ---------------- request decode ----------------
  logic pop_req, push_req;
  assign pop_req  = req_valid && !req_push;
  assign push_req = req_valid &&  req_push;

  logic [SLOTS*8-1:0]      sel_map;
  logic [SLOTS*CNT_W-1:0]  sel_cap;
  logic [CNT_W-1:0]        sel_max, sel_min;
  logic [GRP_W-1:0]        sel_grp;
  logic [N_POOL*CNT_W-1:0] sel_pp;

  assign sel_map = cfg_pool_map[int'(req_policy)*SLOTS*8 +: SLOTS*8];
  assign sel_cap = cfg_slot_max[int'(req_policy)*SLOTS*CNT_W +: SLOTS*CNT_W];
  assign sel_max = cfg_pol_max[int'(req_policy)*CNT_W +: CNT_W];
  assign sel_min = cfg_pol_min[int'(req_policy)*CNT_W +: CNT_W];
  assign sel_grp = cfg_pol_grp[int'(req_policy)*GRP_W +: GRP_W];

  // ---------------- pool free lists ----------------
  logic [PTR_W-1:0] fifo_rd  [N_POOL];
  logic [LW-1:0]    fifo_lvl [N_POOL];
  logic [N_POOL-1:0] fifo_full, fifo_empty, fifo_wr, fifo_rd_en;

  // ---------------- pool choice ----------------
  logic          pk_hit, pk_draw;
  logic [IW-1:0] pk_idx;

  bpa_pick #(.SLOTS(SLOTS), .N_POOL(N_POOL), .CNT_W(CNT_W), .IW(IW)) u_pick (
    .slot_pid (sel_map),
    .slot_cap (sel_cap),
    .pp_cnt   (sel_pp),
    .pol_cnt  (pol_cnt[req_policy]),
    .pol_max  (sel_max),
    .pol_min  (sel_min),
    .grp_free (grp_free[sel_grp]),
    .pop_en   (pool_pop_en),
    .guar_en  (pool_guar_en),
    .nonempty (~fifo_empty),
    .hit      (pk_hit),
    .idx      (pk_idx),
    .draw     (pk_draw)
  );

  logic grant;
  assign grant = pop_req && !pop_dis && pk_hit;

  // ---------------- push decode ----------------
  logic [7:0]    push_pid;
  logic [IW-1:0] push_pi;
  logic          push_ok;
  logic          push_refill;
  logic          unused_word_bits;

  assign push_pid    = req_word[63:56];
  assign push_pi     = push_pid[IW-1:0];
  assign push_ok     = push_req && !push_dis && (push_pid < POOL_LIM) && !fifo_full[push_pi];
  assign push_refill = (pol_cnt[req_policy] > sel_min) || !pool_guar_en[push_pi];
  assign unused_word_bits = ^req_word[55:36];

  genvar gi, gj;
  generate
    for (gi = 0; gi < N_POOL; gi++) begin : g_pool
      assign fifo_wr[gi]    = push_ok && (push_pi == IW'(gi));
      assign fifo_rd_en[gi] = grant   && (pk_idx  == IW'(gi));
      assign sel_pp[gi*CNT_W +: CNT_W] = pp_cnt[req_policy][gi];

      bpa_pool_fifo #(.DEPTH(DEPTH), .DW(PTR_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fifo_wr[gi]),
        .wr_data (req_word[PTR_W-1:0]),
        .rd_en   (fifo_rd_en[gi]),
        .rd_data (fifo_rd[gi]),
        .level   (fifo_lvl[gi]),
        .full    (fifo_full[gi]),
        .empty   (fifo_empty[gi])
      );

      assign pool_pop_cnt [gi*CNT_W +: CNT_W] = pop_cnt[gi];
      assign pool_push_cnt[gi*CNT_W +: CNT_W] = push_cnt[gi];
      assign pool_level   [gi*LW +: LW]       = fifo_lvl[gi];
    end
    for (gj = 0; gj < N_POL; gj++) begin : g_pol
      assign pol_alloc_cnt[gj*CNT_W +: CNT_W] = pol_cnt[gj];
      assign pol_null_cnt [gj*CNT_W +: CNT_W] = null_cnt[gj];
    end
    for (gi = 0; gi < N_GRP; gi++) begin : g_grp
      assign grp_avail[gi*CNT_W +: CNT_W] = grp_free[gi];
    end
  endgenerate

  // ---------------- counters ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < N_POL; p++) begin
        pol_cnt[p]  <= '0;
        null_cnt[p] <= '0;
        for (int q = 0; q < N_POOL; q++) pp_cnt[p][q] <= '0;
      end
      for (int q = 0; q < N_POOL; q++) begin
        pop_cnt[q]  <= '0;
        push_cnt[q] <= '0;
      end
      for (int g = 0; g < N_GRP; g++) grp_free[g] <= cfg_grp_avail[g*CNT_W +: CNT_W];
    end else begin
      if (grant) begin
        pol_cnt[req_policy]         <= pol_cnt[req_policy] + 1'b1;
        pp_cnt[req_policy][pk_idx]  <= pp_cnt[req_policy][pk_idx] + 1'b1;
        if (pop_cnt[pk_idx] != '1) pop_cnt[pk_idx] <= pop_cnt[pk_idx] + 1'b1;
        if (pk_draw) grp_free[sel_grp] <= grp_free[sel_grp] - 1'b1;
      end
      if (pop_req && !grant && (null_cnt[req_policy] != '1))
        null_cnt[req_policy] <= null_cnt[req_policy] + 1'b1;
      if (push_ok) begin
        if (push_cnt[push_pi] != '1) push_cnt[push_pi] <= push_cnt[push_pi] + 1'b1;
        if (pol_cnt[req_policy] != '0) pol_cnt[req_policy] <= pol_cnt[req_policy] - 1'b1;
        if (pp_cnt[req_policy][push_pi] != '0)
          pp_cnt[req_policy][push_pi] <= pp_cnt[req_policy][push_pi] - 1'b1;
        if (push_refill && (grp_free[sel_grp] != '1))
          grp_free[sel_grp] <= grp_free[sel_grp] + 1'b1;
      end
    end
  end

  // ---------------- reply ----------------
  logic          rsp_hit_q;
  logic [IW-1:0] rsp_idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit_q <= 1'b0;
      rsp_idx_q <= '0;
    end else begin
      rsp_valid <= pop_req;
      rsp_hit_q <= grant;
      if (grant) rsp_idx_q <= pk_idx;
    end
  end

  assign rsp_word = rsp_hit_q ? mk_word(8'(rsp_idx_q), fifo_rd[rsp_idx_q]) : NULL_WORD;
endmodule

// File: rtl/bufptr_alloc_chk.sv
module bufptr_alloc_chk #(
  parameter int N_POOL = 4,
  parameter int LW     = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 req_push,
  input logic                 pop_dis,
  input logic                 push_dis,
  input logic                 rsp_valid,
  input logic [63:0]          rsp_word,
  input logic [N_POOL*LW-1:0] pool_level
);
  // R1
  rsp_follows_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_push) |=> rsp_valid);

  // R1
  rsp_needs_pop_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_push));

  // R1
  rsp_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_word[55:36] == 20'h0));

  // R2
  null_ptr_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_word[63:56] == 8'hFF)) |-> (rsp_word[35:0] == {36{1'b1}}));

  // R10
  pop_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_push && pop_dis) |=> (rsp_word[63:56] == 8'hFF));

  // R10
  push_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_push && push_dis) |=> $stable(pool_level));
endmodule

bind bufptr_alloc bufptr_alloc_chk #(.N_POOL(N_POOL), .LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_push   (req_push),
  .pop_dis    (pop_dis),
  .push_dis   (push_dis),
  .rsp_valid  (rsp_valid),
  .rsp_word   (rsp_word),
  .pool_level (pool_level)
);

// File: tb/test_bufptr_alloc.sv
`timescale 1ns/1ps
module test_bufptr_alloc;
  localparam int N_POL = 4, N_POOL = 4, N_GRP = 2, SLOTS = 4, CNT_W = 8, DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [63:0] NULLW = {8'hFF, 20'h0, 36'hF_FFFF_FFFF};

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_push = 1'b0;
  logic [1:0] req_policy = '0;
  logic [63:0] req_word = '0;
  logic pop_dis = 1'b0, push_dis = 1'b0;
  logic [N_POOL-1:0] pool_pop_en = '1, pool_guar_en = '1;
  logic [N_POL*SLOTS*8-1:0]     cfg_pool_map;
  logic [N_POL*SLOTS*CNT_W-1:0] cfg_slot_max;
  logic [N_POL*CNT_W-1:0]       cfg_pol_max, cfg_pol_min;
  logic [N_POL-1:0]             cfg_pol_grp;
  logic [N_GRP*CNT_W-1:0]       cfg_grp_avail;
  logic rsp_valid;
  logic [63:0] rsp_word;
  logic [N_POL*CNT_W-1:0]  pol_alloc_cnt, pol_null_cnt;
  logic [N_POOL*CNT_W-1:0] pool_pop_cnt, pool_push_cnt;
  logic [N_POOL*LW-1:0]    pool_level;
  logic [N_GRP*CNT_W-1:0]  grp_avail;

  int checks = 0, errors = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  bufptr_alloc #(.N_POL(N_POL), .N_POOL(N_POOL), .N_GRP(N_GRP), .SLOTS(SLOTS),
                 .CNT_W(CNT_W), .DEPTH(DEPTH)) i_bufptr_alloc (.*);

  function automatic logic [63:0] okw(input logic [7:0] pid, input logic [35:0] ptr);
    return {pid, 20'h0, ptr};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk("R1 unexpected reply", rsp_word, 64'h0);
      else chk(tag_q.pop_front(), rsp_word, exp_q.pop_front());
    end
  end

  task automatic pop(input int pol, input logic [63:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_push = 1'b0; req_policy = 2'(pol); req_word = '0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic push(input int pol, input logic [7:0] pid, input logic [35:0] ptr);
    req_valid = 1'b1; req_push = 1'b1; req_policy = 2'(pol); req_word = okw(pid, ptr);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_pol(input int p, input logic [31:0] map, input logic [31:0] cap,
                         input logic [7:0] mx, input logic [7:0] mn, input logic g);
    cfg_pool_map[p*32 +: 32]  = map;
    cfg_slot_max[p*32 +: 32]  = cap;
    cfg_pol_max[p*8 +: 8]     = mx;
    cfg_pol_min[p*8 +: 8]     = mn;
    cfg_pol_grp[p]            = g;
  endtask

  initial begin
    // map bytes: slot0 in low byte
    set_pol(0, 32'hFFFF_0100, 32'h0000_0802, 8'd6, 8'd1, 1'b0);
    set_pol(1, 32'hFFFF_FF02, 32'h0000_0008, 8'd3, 8'd3, 1'b1);
    set_pol(2, 32'hFFFF_FF01, 32'h0000_0008, 8'd8, 8'd8, 1'b1);
    set_pol(3, 32'hFFFF_FF03, 32'h0000_0010, 8'd8, 8'd4, 1'b0);
    cfg_grp_avail = {8'd1, 8'd3};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk("R12 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12 pol_alloc", 64'(pol_alloc_cnt), 64'd0);
    chk("R12 null", 64'(pol_null_cnt), 64'd0);
    chk("R12 level", 64'(pool_level), 64'd0);
    chk("R12 grp_avail", 64'(grp_avail), 64'h0103);

    pop(0, NULLW, "R2 empty pools");
    chk("R2 null cnt", 64'(pol_null_cnt[7:0]), 64'd1);

    push(0, 8'd0, 36'h100); push(0, 8'd0, 36'h101); push(0, 8'd0, 36'h102);
    push(0, 8'd1, 36'h200); push(0, 8'd1, 36'h201);
    chk("R8 level0", 64'(pool_level[4:0]), 64'd3);
    chk("R8 push cnt0", 64'(pool_push_cnt[7:0]), 64'd3);
    chk("R9 alloc sat zero", 64'(pol_alloc_cnt[7:0]), 64'd0);
    chk("R9 grp0 unchanged", 64'(grp_avail[7:0]), 64'd3);

    pop(0, okw(8'd0, 36'h100), "R1 R8 first grant");
    chk("R7 guaranteed no draw", 64'(grp_avail[7:0]), 64'd3);
    chk("R7 alloc", 64'(pol_alloc_cnt[7:0]), 64'd1);
    pop(0, okw(8'd0, 36'h101), "R7 second grant");
    chk("R7 draw grp0", 64'(grp_avail[7:0]), 64'd2);
    pop(0, okw(8'd1, 36'h200), "R5 R3 slot cap moves to slot1");
    chk("R7 grp0", 64'(grp_avail[7:0]), 64'd1);

    pool_pop_en[1] = 1'b0;
    pop(0, NULLW, "R4 pool disabled");
    chk("R4 null cnt", 64'(pol_null_cnt[7:0]), 64'd2);
    pool_pop_en[1] = 1'b1;

    pop(0, okw(8'd1, 36'h201), "R3 slot1");
    chk("R7 grp0 empty", 64'(grp_avail[7:0]), 64'd0);
    chk("R13 pop cnt1", 64'(pool_pop_cnt[15:8]), 64'd2);
    chk("R13 level1", 64'(pool_level[9:5]), 64'd0);

    push(2, 8'd1, 36'h202);
    pop(0, NULLW, "R7 group exhausted");
    chk("R7 null cnt", 64'(pol_null_cnt[7:0]), 64'd3);

    push(0, 8'd1, 36'h203);
    chk("R9 refill grp0", 64'(grp_avail[7:0]), 64'd1);
    chk("R9 alloc dec", 64'(pol_alloc_cnt[7:0]), 64'd3);
    pop(0, okw(8'd1, 36'h202), "R8 fifo order");
    chk("R7 grp0 drawn", 64'(grp_avail[7:0]), 64'd0);

    for (int i = 0; i < 4; i++) push(1, 8'd2, 36'h300 + 36'(i));
    for (int i = 0; i < 3; i++) pop(1, okw(8'd2, 36'h300 + 36'(i)), "R6 under max");
    pop(1, NULLW, "R6 policy max");
    chk("R13 pop cnt2", 64'(pool_pop_cnt[23:16]), 64'd3);
    chk("R13 level2", 64'(pool_level[14:10]), 64'd1);
    chk("R7 grp1 untouched", 64'(grp_avail[15:8]), 64'd1);

    pop_dis = 1'b1;
    pop(2, NULLW, "R10 pop disabled");
    chk("R10 level1 kept", 64'(pool_level[9:5]), 64'd1);
    chk("R10 null cnt2", 64'(pol_null_cnt[23:16]), 64'd1);
    pop_dis = 1'b0;
    pop(2, okw(8'd1, 36'h203), "R10 pop re-enabled");

    push_dis = 1'b1;
    push(3, 8'd3, 36'h400);
    chk("R10 push ignored level", 64'(pool_level[19:15]), 64'd0);
    chk("R10 push ignored cnt", 64'(pool_push_cnt[31:24]), 64'd0);
    push_dis = 1'b0;

    push(3, 8'd5, 36'h777);
    chk("R11 bad pool id", 64'(pool_push_cnt), 64'h0004_0403);
    for (int i = 0; i < 17; i++) push(3, 8'd3, 36'h500 + 36'(i));
    chk("R11 full level", 64'(pool_level[19:15]), 64'd16);
    chk("R11 full cnt", 64'(pool_push_cnt[31:24]), 64'd16);

    pool_guar_en[3] = 1'b0;
    pop(3, NULLW, "R7 guarantee off needs group");
    pool_guar_en[3] = 1'b1;
    pop(3, okw(8'd3, 36'h500), "R7 guarantee on");
    chk("R7 grp0 final", 64'(grp_avail[7:0]), 64'd0);

    @(negedge clk);
    chk("R1 all replies seen", 64'(exp_q.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule